// File: doc/BRIEF.md
# Multi-Latency Floating-Point Issue Hazard Checker

This block sits in the decode stage of a pipeline that feeds four execution units. Each unit has a fixed latency: an integer unit, a pipelined adder, a pipelined multiplier, and a divider that is not pipelined. Every cycle the block looks at one decoded instruction. It reads the unit code, two source registers, a destination register and a valid bit, and decides in the same cycle whether the instruction issues or stalls. When an instruction issues, exactly one dispatch line fires, for the unit it selected. A stalled instruction is held at the inputs by the decoder and is checked again on the next cycle.

Four conditions cause a stall:
- A source register is still waiting for an in-flight result (read-after-write).
- The destination register has an older in-flight write that would not land first (write-after-write).
- The divider is still busy.
- The single register-file write port is already claimed for the cycle in which the new result would complete.

Every instruction writes one result. Operands are read at issue, so a later writer never has to wait for an earlier reader.

Top module: `fp_issue_ctrl`

## Requirements
- R1: After reset no register is pending, no write slot is claimed and the divider is idle, so the first valid instruction issues in the cycle it is presented.
- R2: The dispatch output is one-hot with the bit index equal to the unit code (0 integer, 1 adder, 2 multiplier, 3 divider). It is nonzero exactly in cycles where an instruction issues.
- R3: Stall and issue are combinational. Stall is high only while dec_valid is high, and issue equals dec_valid and not stall.
- R4: Take an instruction that issues in cycle t on a unit of latency L (integer 1, adder 4, multiplier 7, divider 24). A later instruction that reads its destination through either source stalls until cycle t+L, and may issue from t+L onward.
- R5: Take an older write to the same destination that would complete in cycle t+L1, where t is the older instruction's issue cycle. A new instruction presented in cycle c with latency L2 stalls while c+L2 <= t+L1.
- R6: Take an instruction that issues in cycle c with latency L. It completes in cycle c+L. No two issued instructions share a completion cycle; the later one stalls instead.
- R7: A divide instruction does not issue within 24 cycles of the previous divide issue.
- R8: The adder and the multiplier accept independent operations in consecutive cycles.
- R9: An instruction whose destination is a source of an older in-flight instruction issues with no stall caused by that overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded instruction is presented |
| dec_unit | input | 2 | Unit code: 0 integer, 1 adder, 2 multiplier, 3 divider |
| dec_src_a | input | 5 | First source register |
| dec_src_b | input | 5 | Second source register |
| dec_dst | input | 5 | Destination register |
| stall | output | 1 | Hold the presented instruction this cycle |
| issue | output | 1 | The presented instruction leaves decode this cycle |
| disp | output | 4 | One-hot dispatch strobe, bit index equals unit code |

## Verification
The assertions check these properties on every cycle:
- Dispatch is one-hot and tracks issue.
- Stall never fires without a valid instruction.
- Divide issues are spaced by the divider latency, which a counter in the checker tracks.
- No two issued instructions complete in the same cycle, which a shadow completion map in the checker tracks.

Only the bench scenarios can show that each hazard releases in the exact cycle it should. They pair every unit with every unit over many presentation gaps, under each dependency pattern. For every pair the bench compares the issue cycle with the earliest cycle that satisfies all of the arithmetic issue rules at once.

// File: rtl/fp_issue_pkg.sv
package fp_issue_pkg;
  typedef enum logic [1:0] {
    FU_INT = 2'd0,
    FU_ADD = 2'd1,
    FU_MUL = 2'd2,
    FU_DIV = 2'd3
  } fu_e;

  localparam int NUM_FU = 4;
endpackage

// File: rtl/fp_pend_table.sv
module fp_pend_table #(
  parameter int NREG  = 32,
  parameter int REG_W = 5,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_reg,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [REG_W-1:0] rd_a,
  input  logic [REG_W-1:0] rd_b,
  input  logic [REG_W-1:0] rd_d,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic [CNT_W-1:0] cnt_d
);
  logic [CNT_W-1:0] remain [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        remain[r] <= '0;
      else if (wr_en && wr_reg == REG_W'(r))
        remain[r] <= wr_cnt;
      else if (remain[r] != '0)
        remain[r] <= remain[r] - 1'b1;
    end
  end

  assign cnt_a = remain[rd_a];
  assign cnt_b = remain[rd_b];
  assign cnt_d = remain[rd_d];
endmodule

// File: rtl/fp_wb_slots.sv
module fp_wb_slots #(
  parameter int DEPTH = 24,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim,
  input  logic [CNT_W-1:0] lat,
  output logic             slot_hit
);
  // taken[k]: the write port is already claimed k cycles from now
  logic [DEPTH:1] taken;
  logic [DEPTH:1] taken_n;

  for (genvar k = 1; k < DEPTH; k++) begin : g_shift
    assign taken_n[k] = taken[k+1] | (claim && lat == CNT_W'(k + 1));
  end
  assign taken_n[DEPTH] = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) taken <= '0;
    else        taken <= taken_n;
  end

  always_comb begin
    slot_hit = 1'b0;
    for (int k = 1; k <= DEPTH; k++)
      if (taken[k] && lat == CNT_W'(k)) slot_hit = 1'b1;
  end
endmodule

// File: rtl/fp_unit_gate.sv
module fp_unit_gate #(
  parameter int INTERVAL = 24,
  parameter int CNT_W    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)         left <= '0;
    else if (start)     left <= CNT_W'(INTERVAL - 1);
    else if (left != 0) left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/fp_issue_ctrl.sv
module fp_issue_ctrl
  import fp_issue_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 7,
  parameter int LAT_DIV = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_valid,
  input  logic [1:0]               dec_unit,
  input  logic [$clog2(NREG)-1:0]  dec_src_a,
  input  logic [$clog2(NREG)-1:0]  dec_src_b,
  input  logic [$clog2(NREG)-1:0]  dec_dst,
  output logic                     stall,
  output logic                     issue,
  output logic [NUM_FU-1:0]        disp
);
  localparam int REG_W = $clog2(NREG);
  localparam int CNT_W = $clog2(LAT_DIV + 1);

  function automatic logic [CNT_W-1:0] unit_lat(input logic [1:0] u);
    case (fu_e'(u))
      FU_INT:  return CNT_W'(LAT_INT);
      FU_ADD:  return CNT_W'(LAT_ADD);
      FU_MUL:  return CNT_W'(LAT_MUL);
      default: return CNT_W'(LAT_DIV);
    endcase
  endfunction

  logic [CNT_W-1:0] lat;
  logic [CNT_W-1:0] cnt_a, cnt_b, cnt_d;
  logic             hz_raw, hz_waw, hz_port, hz_unit;
  logic             div_busy, div_start;

  assign lat = unit_lat(dec_unit);

  fp_pend_table #(.NREG(NREG), .REG_W(REG_W), .CNT_W(CNT_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .wr_en(issue), .wr_reg(dec_dst), .wr_cnt(lat - 1'b1),
    .rd_a(dec_src_a), .rd_b(dec_src_b), .rd_d(dec_dst),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_d(cnt_d)
  );

  fp_wb_slots #(.DEPTH(LAT_DIV), .CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .claim(issue), .lat(lat), .slot_hit(hz_port)
  );

  assign div_start = issue && (fu_e'(dec_unit) == FU_DIV);

  fp_unit_gate #(.INTERVAL(LAT_DIV), .CNT_W(CNT_W)) u_div_gate (
    .clk(clk), .rst_n(rst_n), .start(div_start), .busy(div_busy)
  );

  // hazard events, named for observation
  assign hz_raw  = (cnt_a != '0) || (cnt_b != '0);
  assign hz_waw  = (cnt_d >= lat);
  assign hz_unit = div_busy && (fu_e'(dec_unit) == FU_DIV);

  assign stall = dec_valid && (hz_raw || hz_waw || hz_port || hz_unit);
  assign issue = dec_valid && !stall;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_disp
    assign disp[u] = issue && (dec_unit == 2'(u));
  end
endmodule

// File: rtl/fp_issue_chk.sv
module fp_issue_chk #(
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 7,
  parameter int LAT_DIV = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_valid,
  input logic [1:0] dec_unit,
  input logic       stall,
  input logic       issue,
  input logic [3:0] disp
);
  localparam int CW = $clog2(LAT_DIV + 1);

  function automatic int chk_lat(input logic [1:0] u);
    case (u)
      2'd0:    return LAT_INT;
      2'd1:    return LAT_ADD;
      2'd2:    return LAT_MUL;
      default: return LAT_DIV;
    endcase
  endfunction

  logic [CW-1:0]    since_div;
  logic [LAT_DIV:1] done_map;
  logic             clash;

  always_ff @(posedge clk) begin
    if (!rst_n)                 since_div <= CW'(LAT_DIV);
    else if (disp[3])           since_div <= CW'(1);
    else if (since_div < CW'(LAT_DIV)) since_div <= since_div + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_map <= '0;
    else begin
      for (int k = 1; k < LAT_DIV; k++)
        done_map[k] <= done_map[k+1] | (issue && chk_lat(dec_unit) == k + 1);
      done_map[LAT_DIV] <= 1'b0;
    end
  end

  always_comb begin
    clash = 1'b0;
    for (int k = 1; k <= LAT_DIV; k++)
      if (done_map[k] && chk_lat(dec_unit) == k) clash = 1'b1;
  end

  AST_DISP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp) && ((disp != 4'b0) == issue)); // R2
  AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> dec_valid); // R3
  AST_ISSUE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (dec_valid && !stall)); // R3
  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    disp[3] |-> since_div >= CW'(LAT_DIV)); // R7
  AST_ONE_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !clash); // R6
endmodule

bind fp_issue_ctrl fp_issue_chk #(
  .LAT_INT(LAT_INT), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
  .stall(stall), .issue(issue), .disp(disp)
);

// File: tb/sim_fp_issue_ctrl.sv
module sim_fp_issue_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid = 1'b0;
  logic [1:0] dec_unit = '0;
  logic [4:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic       stall, issue;
  logic [3:0] disp;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fp_issue_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
    .stall(stall), .issue(issue), .disp(disp)
  );

  function automatic int tb_lat(input int u);
    return (u == 0) ? 1 : (u == 1) ? 4 : (u == 2) ? 7 : 24;
  endfunction

  // earliest issue offset of the second instruction, from the rules
  function automatic int earliest(input int u1, input int u2, input int kind,
                                  input int p);
    int l1 = tb_lat(u1), l2 = tb_lat(u2);
    for (int d = p; d < 60; d++) begin
      bit ok = 1'b1;
      if ((kind == 1 || kind == 2) && d < l1) ok = 1'b0;   // R4
      if (kind == 3 && d + l2 <= l1) ok = 1'b0;            // R5
      if (d + l2 == l1) ok = 1'b0;                         // R6
      if (u1 == 3 && u2 == 3 && d < 24) ok = 1'b0;         // R7
      if (ok) return d;
    end
    return -1;
  endfunction

  task automatic check(input bit cond, input string req, input int act,
                       input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic present(input int u, input int a, input int b, input int d);
    dec_valid = 1'b1; dec_unit = 2'(u);
    dec_src_a = 5'(a); dec_src_b = 5'(b); dec_dst = 5'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dec_valid = 1'b0;
      #2;
      check(!stall && !issue && disp == 4'b0, "R3", int'(stall), 0);
      @(posedge clk);
    end
  endtask

  task automatic scenario(input int u1, input int u2, input int kind,
                          input int p);
    int sa, sb, sd, exp_d, got_d;
    @(negedge clk);
    present(u1, 1, 2, 3);
    #2;
    check(issue && disp == 4'(1 << u1), "R1/R2 first issue", int'(disp),
          1 << u1);
    @(posedge clk);
    for (int c = 1; c < p; c++) begin
      @(negedge clk);
      dec_valid = 1'b0;
      #2;
      check(!stall, "R3", int'(stall), 0);
      @(posedge clk);
    end
    case (kind)
      1:       begin sa = 3; sb = 5; sd = 6; end  // R4 via source a
      2:       begin sa = 4; sb = 3; sd = 6; end  // R4 via source b
      3:       begin sa = 4; sb = 5; sd = 3; end  // R5 same destination
      4:       begin sa = 4; sb = 5; sd = 1; end  // R9 overwrites a read reg
      default: begin sa = 4; sb = 5; sd = 6; end
    endcase
    exp_d = earliest(u1, u2, kind, p);
    got_d = -1;
    for (int c = p; c < 60 && got_d < 0; c++) begin
      @(negedge clk);
      present(u2, sa, sb, sd);
      #2;
      if (issue) begin
        got_d = c;
        check(disp == 4'(1 << u2), "R2", int'(disp), 1 << u2);
      end else begin
        check(disp == 4'b0, "R2 stalled", int'(disp), 0);
      end
      @(posedge clk);
    end
    check(got_d == exp_d,
          (kind == 4) ? "R9" : (kind == 0 && u1 == u2 && p == 1) ? "R8" :
          "R4/R5/R6/R7", got_d, exp_d);
    idle(26);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(!stall && !issue && disp == 4'b0, "R1 reset", int'(disp), 0);
    // R8: adder then multiplier streams back to back
    for (int u = 1; u <= 2; u++) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        present(u, 10, 11, 12 + i);
        #2;
        check(issue, "R8", int'(issue), 1);
        @(posedge clk);
      end
      idle(26);
    end
    for (int u1 = 0; u1 < 4; u1++)
      for (int u2 = 0; u2 < 4; u2++)
        for (int kind = 0; kind < 5; kind++)
          for (int pi = 0; pi < 12; pi++)
            scenario(u1, u2, kind, (pi < 8) ? pi + 1 : pi + 15);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule